// File: doc/BRIEF.md
# Days-in-Month Decoder with BCD Leap-Year Detection

This block tells a watch display how long the current month is. It takes a binary month number and a four-digit BCD year. It drives a one-hot vector with four lanes, one for each possible month length: 28, 29, 30 and 31 days.

The leap-year decision is made directly on the BCD digits. Small divisibility detectors check for divisibility by 4, by 100 and by 400. Their results, and the resulting leap flag, are also brought out as ports so they can be observed.

The block is purely combinational. It holds no state and has no clock. Years are assumed to be Gregorian, from 1583 onward. Each BCD digit is assumed to be a legal code from 0 to 9.

Top module: `cal_days_decoder`

## Requirements
- R1: For every month code from 1 to 12, `days_oh` has exactly one bit set. The bit encoding is: bit 0 = 28 days, bit 1 = 29 days, bit 2 = 30 days, bit 3 = 31 days.
- R2: For month 2, `days_oh` is 4'b0010 when `leap` is high and 4'b0001 when `leap` is low.
- R3: Months 4, 6, 9 and 11 give `days_oh` = 4'b0100.
- R4: Months 1, 3, 5, 7, 8, 10 and 12 give `days_oh` = 4'b1000.
- R5: Month codes 0, 13, 14 and 15 give `days_oh` = 4'b0000.
- R6: `div4` is high exactly when the number formed by the tens digit (`year_bcd[7:4]`) and the ones digit (`year_bcd[3:0]`) is a multiple of 4.
- R7: `div100` is high exactly when the tens digit and the ones digit are both zero.
- R8: `div400` is high exactly when `div100` is high and the number formed by the thousands digit (`year_bcd[15:12]`) and the hundreds digit (`year_bcd[11:8]`) is a multiple of 4.
- R9: `leap` is high exactly when the year is a Gregorian leap year. That means it is divisible by 4, and either not divisible by 100 or divisible by 400.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| month | input | 4 | Binary month number, 1 = January |
| year_bcd | input | 16 | Year as four BCD digits, thousands digit in the top nibble |
| days_oh | output | 4 | One-hot month length; bit 0 = 28, bit 1 = 29, bit 2 = 30, bit 3 = 31 |
| leap | output | 1 | Leap-year flag |
| div4 | output | 1 | Year divisible by 4 |
| div100 | output | 1 | Year divisible by 100 |
| div400 | output | 1 | Year divisible by 400 |

## Verification
Every output is a pure function of `month` and `year_bcd`, so each result is due in the same cycle as its stimulus, with zero register delay. The bench applies new inputs on the falling clock edge and samples all outputs one nanosecond later, before any further input change. This means no check ever looks across a clock edge. The expected values come from converting the BCD year to an integer and taking integer remainders, compared against each month's length.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned DIGIT_W   = 4;
  localparam int unsigned NUM_DIGIT = 4;
  localparam int unsigned YEAR_W    = DIGIT_W * NUM_DIGIT;
  localparam int unsigned MONTH_W   = 4;
  localparam int unsigned LEN_W     = 4;

  // Lane index inside the one-hot month-length vector
  typedef enum logic [1:0] {
    LEN_28 = 2'd0,
    LEN_29 = 2'd1,
    LEN_30 = 2'd2,
    LEN_31 = 2'd3
  } len_lane_e;

  localparam logic [MONTH_W-1:0] MON_FIRST = MONTH_W'(1);
  localparam logic [MONTH_W-1:0] MON_LAST  = MONTH_W'(12);
  localparam logic [MONTH_W-1:0] MON_FEB   = MONTH_W'(2);
endpackage

// File: rtl/cal_bcd_pair_div4.sv
// Decides whether a two-digit BCD number is a multiple of four.
// Only the low bit of the upper digit matters: an even upper digit
// needs a lower digit in {0,4,8}, an odd one needs {2,6}.
module cal_bcd_pair_div4 #(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic               hi_lsb,
  input  logic [DIGIT_W-1:0] lo_digit,
  output logic               is_mult4
);
  localparam logic [DIGIT_W-1:0] D0 = DIGIT_W'(0);
  localparam logic [DIGIT_W-1:0] D2 = DIGIT_W'(2);
  localparam logic [DIGIT_W-1:0] D4 = DIGIT_W'(4);
  localparam logic [DIGIT_W-1:0] D6 = DIGIT_W'(6);
  localparam logic [DIGIT_W-1:0] D8 = DIGIT_W'(8);

  logic even_ok;
  logic odd_ok;

  always_comb begin
    even_ok  = (lo_digit == D0) || (lo_digit == D4) || (lo_digit == D8);
    odd_ok   = (lo_digit == D2) || (lo_digit == D6);
    is_mult4 = hi_lsb ? odd_ok : even_ok;
  end
endmodule

// File: rtl/cal_leap_unit.sv
// Divisibility detectors and leap flag for a BCD year.
module cal_leap_unit
  import cal_pkg::*;
(
  input  logic [YEAR_W-1:0] year_bcd,
  output logic              div4,
  output logic              div100,
  output logic              div400,
  output logic              leap
);
  localparam int unsigned NPAIR = NUM_DIGIT / 2;

  // pair 0 = tens/ones, pair 1 = thousands/hundreds
  logic [NPAIR-1:0] pair_m4;

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    localparam int unsigned LO = 2 * g * DIGIT_W;
    localparam int unsigned HI = LO + DIGIT_W;
    cal_bcd_pair_div4 #(.DIGIT_W(DIGIT_W)) u_pair (
      .hi_lsb   (year_bcd[HI]),
      .lo_digit (year_bcd[LO +: DIGIT_W]),
      .is_mult4 (pair_m4[g])
    );
  end

  logic low_pair_zero;
  logic unused_upper_bits;

  always_comb begin
    low_pair_zero = (year_bcd[2*DIGIT_W-1:0] == '0);
    div4          = pair_m4[0];
    div100        = low_pair_zero;
    div400        = pair_m4[1] & low_pair_zero;
    leap          = div4 & (~div100 | div400);
  end

  assign unused_upper_bits = ^{year_bcd[YEAR_W-1 -: DIGIT_W-1],
                               year_bcd[3*DIGIT_W-1 -: DIGIT_W-1]};
endmodule

// File: rtl/cal_len_decode.sv
// Maps month number and leap flag onto the one-hot length vector.
module cal_len_decode
  import cal_pkg::*;
(
  input  logic [MONTH_W-1:0] month,
  input  logic               leap,
  output logic [LEN_W-1:0]   len_oh
);
  logic valid;
  logic is_feb;
  logic is_short;

  always_comb begin
    valid    = (month >= MON_FIRST) && (month <= MON_LAST);
    is_feb   = (month == MON_FEB);
    is_short = (month == MONTH_W'(4)) || (month == MONTH_W'(6)) ||
               (month == MONTH_W'(9)) || (month == MONTH_W'(11));
    len_oh   = '0;
    if (valid) begin
      if (is_feb) begin
        len_oh[leap ? LEN_29 : LEN_28] = 1'b1;
      end else if (is_short) begin
        len_oh[LEN_30] = 1'b1;
      end else begin
        len_oh[LEN_31] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cal_days_decoder.sv
module cal_days_decoder
  import cal_pkg::*;
(
  input  logic [MONTH_W-1:0] month,
  input  logic [YEAR_W-1:0]  year_bcd,
  output logic [LEN_W-1:0]   days_oh,
  output logic               leap,
  output logic               div4,
  output logic               div100,
  output logic               div400
);
  cal_leap_unit u_leap (
    .year_bcd (year_bcd),
    .div4     (div4),
    .div100   (div100),
    .div400   (div400),
    .leap     (leap)
  );

  cal_len_decode u_len (
    .month  (month),
    .leap   (leap),
    .len_oh (days_oh)
  );
endmodule

// File: rtl/cal_days_decoder_chk.sv
module cal_days_decoder_chk
  import cal_pkg::*;
(
  input logic [MONTH_W-1:0] month,
  input logic [YEAR_W-1:0]  year_bcd,
  input logic [LEN_W-1:0]   days_oh,
  input logic               leap,
  input logic               div4,
  input logic               div100,
  input logic               div400
);
  logic mon_ok;
  assign mon_ok = (month >= MON_FIRST) && (month <= MON_LAST);

  always_comb begin
    if (!$isunknown({month, year_bcd})) begin
      AST_ONEHOT_VALID: assert (!mon_ok || $countones(days_oh) == 1); // R1
      AST_FEB_TRACKS_LEAP: assert (month != MON_FEB || days_oh[1] == leap); // R2
      AST_SHORT_MONTH: assert (!(month == 4'd4 || month == 4'd6 || month == 4'd9 || month == 4'd11) || days_oh == 4'b0100); // R3
      AST_BAD_MONTH_DARK: assert (mon_ok || days_oh == '0); // R5
      AST_CENTURY_MULT4: assert (!div100 || div4); // R7
      AST_D400_NEEDS_D100: assert (!div400 || div100); // R8
      AST_LEAP_NEEDS_D4: assert (!leap || div4); // R9
    end
  end
endmodule

bind cal_days_decoder cal_days_decoder_chk u_chk (
  .month    (month),
  .year_bcd (year_bcd),
  .days_oh  (days_oh),
  .leap     (leap),
  .div4     (div4),
  .div100   (div100),
  .div400   (div400)
);

// File: tb/cal_days_decoder_tb.sv
module cal_days_decoder_tb;
  logic       clk;
  logic [3:0] month;
  logic [15:0] year_bcd;
  logic [3:0] days_oh;
  logic       leap, div4, div100, div400;
  int n_chk = 0;
  int n_fail = 0;

  cal_days_decoder u_dut (
    .month(month), .year_bcd(year_bcd), .days_oh(days_oh),
    .leap(leap), .div4(div4), .div100(div100), .div400(div400)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  localparam int NYEAR = 16;
  localparam int YEARS [NYEAR] = '{1583, 1600, 1700, 1800, 1900, 1996, 2000, 2012,
                                   2023, 2024, 2100, 2400, 2404, 2026, 9996, 9999};

  function automatic logic [15:0] to_bcd(input int y);
    return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  function automatic int ref_len(input int m, input bit lp);
    case (m)
      2: return lp ? 29 : 28;
      4, 6, 9, 11: return 30;
      1, 3, 5, 7, 8, 10, 12: return 31;
      default: return 0;
    endcase
  endfunction

  function automatic logic [3:0] len_to_oh(input int d);
    case (d)
      28: return 4'b0001;
      29: return 4'b0010;
      30: return 4'b0100;
      31: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (month %0d year %h)",
               req, what, act, exp, month, year_bcd);
    end
  endtask

  task automatic apply(input int m, input int y);
    @(negedge clk);
    month    = 4'(m);
    year_bcd = to_bcd(y);
    #1;
  endtask

  task automatic check_year_flags(input int y);
    bit e4, e100, e400, elp;
    e4   = (y % 4) == 0;
    e100 = (y % 100) == 0;
    e400 = (y % 400) == 0;
    elp  = e4 && (!e100 || e400);
    chk("R6", int'(div4), int'(e4), "div4");
    chk("R7", int'(div100), int'(e100), "div100");
    chk("R8", int'(div400), int'(e400), "div400");
    chk("R9", int'(leap), int'(elp), "leap");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    string tag;
    bit lp;
    month = '0;
    year_bcd = '0;

    // Initial state: month 0 must leave every length lane dark (R5)
    apply(0, 2024);
    chk("R5", int'(days_oh), 0, "initial invalid month");

    // Table walk: every month code against each table year
    for (int yi = 0; yi < NYEAR; yi++) begin
      for (int m = 0; m < 16; m++) begin
        apply(m, YEARS[yi]);
        lp = (YEARS[yi] % 4 == 0) && ((YEARS[yi] % 100 != 0) || (YEARS[yi] % 400 == 0));
        if (m == 0 || m > 12) tag = "R5";
        else if (m == 2) tag = "R2";
        else if (m == 4 || m == 6 || m == 9 || m == 11) tag = "R3";
        else tag = "R4";
        chk(tag, int'(days_oh), int'(len_to_oh(ref_len(m, lp))), "days_oh");
        if (m >= 1 && m <= 12)
          chk("R1", $countones(days_oh), 1, "one-hot count");
      end
      check_year_flags(YEARS[yi]);
    end

    // Directed: every tens/ones pair within one century
    for (int lo = 0; lo < 100; lo++) begin
      apply(2, 1900 + lo);
      check_year_flags(1900 + lo);
    end

    // Directed: every thousands/hundreds pair from 1600 up, at a century year
    for (int hi = 16; hi < 100; hi++) begin
      apply(2, hi * 100);
      check_year_flags(hi * 100);
      lp = (hi % 4) == 0;
      chk("R2", int'(days_oh), lp ? 2 : 1, "century February");
    end

    // Corner cases: 1900, 2000, 2024 February
    apply(2, 1900);
    chk("R2", int'(days_oh), 1, "Feb 1900");
    apply(2, 2000);
    chk("R2", int'(days_oh), 2, "Feb 2000");
    apply(2, 2024);
    chk("R2", int'(days_oh), 2, "Feb 2024");
    apply(15, 2000);
    chk("R5", int'(days_oh), 0, "month 15");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule